// File: doc/BRIEF.md
# Global-History Set-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one shared shift register with the outcomes of the most recently resolved branches, wherever they sit in the program. The low bits of a branch address pick a row of 2-bit saturating counters. The current history value then picks one counter inside that row. The top bit of that counter is the guess.

A fetch stage presents a branch address on the predict side and reads the direction in the same cycle. When the branch resolves, the execute stage presents its address and real outcome on the update side. The block then trains the one counter that this branch and the history in force before it select. After that it shifts the outcome into the history.

Only part of the address takes part in row selection, so unrelated branches can share counters; that sharing is intended. With zero history bits the block becomes a plain table of 2-bit counters indexed by address.

Top module: `gas_predictor`

## Requirements
- R1: After synchronous reset the history holds all zeros (not taken) and every counter holds 01 (weakly not taken), so every address predicts not taken.
- R2: `pred_taken` is bit 1 of the counter at index {`pred_pc[PC_LSB +: ADDR_BITS]`, history}, with the address bits as the upper part and the history as the lower part (`PC_LSB` = 2 by default). It is combinational in the predict inputs and the current state.
- R3: An update trains only the counter at {`upd_pc[PC_LSB +: ADDR_BITS]`, history before this update}. Every other counter keeps its value.
- R4: An update shifts `upd_taken` (1 = taken) into history bit 0 and drops the oldest bit. In a cycle without an update the history does not change.
- R5: A taken update adds one to the selected counter and a not-taken update subtracts one. The counter saturates at 00 and 11.
- R6: A counter in a strong state (00 or 11) flips its predicted direction only after two opposing outcomes in a row.
- R7: Address bits outside `pred_pc[PC_LSB +: ADDR_BITS]` have no effect. Branches that agree in those bits share counters.
- R8: With `HIST_BITS` = 0 the block is a table of 2^`ADDR_BITS` counters indexed by address alone.
- R9: An update in the same cycle as a prediction of the same counter is not seen by that prediction. It becomes visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_WIDTH | Address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_WIDTH | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
The bench builds two copies of the block side by side on the same stimulus.
- The default copy has two history bits and eight address bits, giving 1024 counters. It exercises history-driven counter selection, the shift order and aliasing through address bits above the index.
- The second copy has zero history bits and four address bits. Its counter selection depends on the address alone, which makes saturation and the two-miss hysteresis directly observable. Its small table lets a pseudo-random address stream revisit every counter many times.

// File: rtl/gas_pkg.sv
package gas_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    typedef struct packed {
        logic valid;
        logic taken;
    } resolve_t;

    function automatic ctr_e ctr_next(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_dir(input ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/gas_history.sv
module gas_history #(
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  gas_pkg::resolve_t    res,
    output logic [HIST_BITS-1:0] hist
);
    generate
        if (HIST_BITS == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else if (res.valid) hist <= res.taken;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else if (res.valid) hist <= {hist[HIST_BITS-2:0], res.taken};
            end
        end
    endgenerate
endmodule

// File: rtl/gas_index.sv
module gas_index #(
    parameter int ADDR_BITS = 8,
    parameter int HIST_BITS = 2,
    localparam int HW    = (HIST_BITS > 0) ? HIST_BITS : 1,
    localparam int IDX_W = ADDR_BITS + HIST_BITS
) (
    input  logic [ADDR_BITS-1:0] row,
    input  logic [HW-1:0]        hist,
    output logic [IDX_W-1:0]     idx
);
    generate
        if (HIST_BITS == 0) begin : g_flat
            logic unused_hist;
            assign unused_hist = ^hist;
            assign idx = row;
        end else begin : g_corr
            assign idx = {row, hist};
        end
    endgenerate
endmodule

// File: rtl/gas_table.sv
module gas_table #(
    parameter int IDX_W = 10,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [IDX_W-1:0]       rd_idx,
    output gas_pkg::ctr_e          rd_ctr,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_taken,
    output gas_pkg::ctr_e          wr_ctr,
    output logic [2*ENTRIES-1:0]   table_flat
);
    import gas_pkg::*;

    ctr_e slots [ENTRIES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) slots[i] <= CTR_WEAK_NT;
            else if (wr_en && wr_idx == IDX_W'(i)) slots[i] <= ctr_next(slots[i], wr_taken);
        end
    end

    assign rd_ctr = slots[rd_idx];
    assign wr_ctr = slots[wr_idx];

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
            assign table_flat[2*g +: 2] = slots[g];
        end
    endgenerate
endmodule

// File: rtl/gas_predictor.sv
module gas_predictor #(
    parameter int HIST_BITS = 2,
    parameter int ADDR_BITS = 8,
    parameter int PC_WIDTH  = 32,
    parameter int PC_LSB    = 2,
    localparam int HW      = (HIST_BITS > 0) ? HIST_BITS : 1,
    localparam int IDX_W   = ADDR_BITS + HIST_BITS,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PC_WIDTH-1:0] pred_pc,
    output logic                pred_taken,
    input  logic                upd_valid,
    input  logic [PC_WIDTH-1:0] upd_pc,
    input  logic                upd_taken
);
    import gas_pkg::*;

    logic [HW-1:0]        hist_q;
    logic [IDX_W-1:0]     pred_idx;
    logic [IDX_W-1:0]     upd_idx;
    ctr_e                 pred_ctr;
    ctr_e                 upd_ctr;
    logic [2*ENTRIES-1:0] table_flat;
    resolve_t             res;
    logic                 unused_pc_bits;

    assign res.valid = upd_valid;
    assign res.taken = upd_taken;
    assign unused_pc_bits = ^{pred_pc, upd_pc};

    generate
        if (HIST_BITS > 0) begin : g_hist
            gas_history #(.HIST_BITS(HIST_BITS)) u_hist (
                .clk(clk), .rst(rst), .res(res), .hist(hist_q)
            );
        end else begin : g_nohist
            assign hist_q = '0;
        end
    endgenerate

    gas_index #(.ADDR_BITS(ADDR_BITS), .HIST_BITS(HIST_BITS)) u_pidx (
        .row(pred_pc[PC_LSB +: ADDR_BITS]), .hist(hist_q), .idx(pred_idx)
    );

    gas_index #(.ADDR_BITS(ADDR_BITS), .HIST_BITS(HIST_BITS)) u_uidx (
        .row(upd_pc[PC_LSB +: ADDR_BITS]), .hist(hist_q), .idx(upd_idx)
    );

    gas_table #(.IDX_W(IDX_W)) u_tab (
        .clk(clk), .rst(rst),
        .rd_idx(pred_idx), .rd_ctr(pred_ctr),
        .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken),
        .wr_ctr(upd_ctr), .table_flat(table_flat)
    );

    assign pred_taken = ctr_dir(pred_ctr);
endmodule

// File: rtl/gas_checker.sv
module gas_checker #(
    parameter int HIST_BITS = 2,
    parameter int IDX_W     = 10,
    localparam int HW      = (HIST_BITS > 0) ? HIST_BITS : 1,
    localparam int ENTRIES = 1 << IDX_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 upd_valid,
    input logic                 upd_taken,
    input logic [HW-1:0]        hist,
    input logic [IDX_W-1:0]     upd_idx,
    input logic [1:0]           upd_ctr,
    input logic [2*ENTRIES-1:0] table_flat
);
    logic [2*ENTRIES-1:0] prev_flat;
    logic [ENTRIES-1:0]   slot_chg;

    always_ff @(posedge clk) prev_flat <= table_flat;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++)
            slot_chg[i] = (table_flat[2*i +: 2] != prev_flat[2*i +: 2]);
    end

    // R3: one counter at most changes per update, none without update
    assert_single_slot_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_chg) <= 1);
    assert_idle_table_R3: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(table_flat));

    // R4: history holds without an update
    assert_idle_hist_R4: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(hist));

    generate
        if (HIST_BITS > 1) begin : g_shift
            assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
                upd_valid |=> hist == {$past(hist[HW-2:0]), $past(upd_taken)});
        end
    endgenerate

    // R5: step and saturation of the trained counter
    assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && upd_ctr != 2'b11) |=>
        table_flat[2*$past(upd_idx) +: 2] == $past(upd_ctr) + 2'd1);
    assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && upd_ctr != 2'b00) |=>
        table_flat[2*$past(upd_idx) +: 2] == $past(upd_ctr) - 2'd1);
    assert_sat_high_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && upd_ctr == 2'b11) |=>
        table_flat[2*$past(upd_idx) +: 2] == 2'b11);
    assert_sat_low_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && upd_ctr == 2'b00) |=>
        table_flat[2*$past(upd_idx) +: 2] == 2'b00);
endmodule

bind gas_predictor gas_checker #(.HIST_BITS(HIST_BITS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_taken(upd_taken),
    .hist(hist_q), .upd_idx(upd_idx), .upd_ctr(upd_ctr), .table_flat(table_flat)
);

// File: tb/gas_predictor_test.sv
module gas_predictor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pred_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        pt_corr;
    logic        pt_flat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gas_predictor #(.HIST_BITS(2), .ADDR_BITS(8)) uut (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pt_corr),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    gas_predictor #(.HIST_BITS(0), .ADDR_BITS(4)) uut_flat (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pt_flat),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    // behavioural reference: counters as integers, history as an integer
    int hist_m;
    int ctr_m [1024];
    int ctr_f [16];

    function automatic int idx_c(input logic [31:0] pc);
        return ((int'(pc >> 2) & 255) * 4) + hist_m;
    endfunction

    function automatic int idx_f(input logic [31:0] pc);
        return int'(pc >> 2) & 15;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist_m = 0;
            for (int i = 0; i < 1024; i++) ctr_m[i] = 1;
            for (int i = 0; i < 16; i++) ctr_f[i] = 1;
        end else if (upd_valid) begin
            int a;
            int b;
            a = idx_c(upd_pc);
            b = idx_f(upd_pc);
            if (upd_taken) begin
                if (ctr_m[a] < 3) ctr_m[a]++;
                if (ctr_f[b] < 3) ctr_f[b]++;
            end else begin
                if (ctr_m[a] > 0) ctr_m[a]--;
                if (ctr_f[b] > 0) ctr_f[b]--;
            end
            hist_m = ((hist_m * 2) + (upd_taken ? 1 : 0)) % 4;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pc=%h actual=%b expected=%b", tag, pred_pc, act, exp);
        end
    endtask

    task automatic cyc(input logic [31:0] ppc, input logic uv, input logic [31:0] upc,
                       input logic ut, input string tag);
        @(negedge clk);
        pred_pc = ppc;
        upd_valid = uv;
        upd_pc = upc;
        upd_taken = ut;
        #2;
        check(tag, pt_corr, ctr_m[idx_c(ppc)] >= 2);
        check({tag, " R8"}, pt_flat, ctr_f[idx_f(ppc)] >= 2);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, every address not taken
        for (int i = 0; i < 8; i++) begin
            cyc(32'(i * 52), 1'b0, '0, 1'b0, "R1");
            check("R1 reset", pt_corr, 1'b0);
        end

        // R5 and R6: saturate taken, then two misses needed to flip
        for (int i = 0; i < 5; i++) cyc(32'h100, 1'b1, 32'h100, 1'b1, "R5");
        cyc(32'h100, 1'b0, '0, 1'b0, "R5");
        check("R5 saturated high", pt_flat, 1'b1);
        cyc(32'h100, 1'b1, 32'h100, 1'b0, "R6");
        cyc(32'h100, 1'b0, '0, 1'b0, "R6");
        check("R6 one miss keeps taken", pt_flat, 1'b1);
        cyc(32'h100, 1'b1, 32'h100, 1'b0, "R6");
        cyc(32'h100, 1'b0, '0, 1'b0, "R6");
        check("R6 two misses flip", pt_flat, 1'b0);
        for (int i = 0; i < 4; i++) cyc(32'h100, 1'b1, 32'h100, 1'b0, "R5");

        // R4: history shift pattern, predictions at other addresses
        for (int i = 0; i < 12; i++) cyc(32'h40 + 32'(i * 4), 1'b1, 32'h40, (i % 3) == 0, "R4");
        for (int i = 0; i < 6; i++) cyc(32'h40 + 32'(i * 4), 1'b0, '0, 1'b0, "R4");

        // R3: train one address, look around it
        for (int i = 0; i < 3; i++) cyc(32'h300, 1'b1, 32'h300, 1'b1, "R3");
        for (int i = 0; i < 8; i++) cyc(32'h2F0 + 32'(i * 4), 1'b0, '0, 1'b0, "R3");

        // R7: address bits above the index alias
        for (int i = 0; i < 4; i++) cyc(32'h200, 1'b1, 32'h200, 1'b1, "R7");
        cyc(32'h0010_0200, 1'b0, '0, 1'b0, "R7");
        cyc(32'hFFF0_0201, 1'b0, '0, 1'b0, "R7");

        // R9: same-cycle update of the predicted counter is not seen
        for (int i = 0; i < 6; i++) cyc(32'h380, 1'b1, 32'h380, 1'b1, "R9");
        for (int i = 0; i < 6; i++) cyc(32'h380, 1'b1, 32'h380, 1'b0, "R9");

        // R2: pseudo-random mixed stream
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = {22'd0, lfsr[7:0], 2'b00};
            b = {22'd0, lfsr[15:12], lfsr[3:0], 2'b00};
            cyc(a, lfsr[9] | lfsr[11], b, lfsr[1] ^ lfsr[14], "R2");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule